// File: doc/BRIEF.md
# Masked Interrupt Status Unit with Acknowledge Reply

This unit keeps an 8-bit pending-event register and an 8-bit enable mask. It drives an active-low interrupt line toward the host. Three sources raise pending bits:

- a once-per-second tick, made by an internal clock divider;
- the completion of an explicit peripheral-bus request;
- an unsolicited autopoll result from the same bus.

The bus itself is outside the unit. It appears only as a completion strobe, a length and a data vector, which the unit formats into a small reply buffer.

The host talks to the unit through two commands, each presented for one cycle with an argument count.

- **Set-mask** replaces the enable mask.
- **Acknowledge** produces a reply and clears what it reported.

The acknowledge reply is prioritised. When a bus event is pending, the reply carries only the two bus-related flags followed by the buffered bus bytes, and every other pending bit is left as it was. Otherwise the reply is the whole pending byte, which is then cleared. The reply is presented in parallel, for one cycle, together with its length.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset the mask is 0x18, the pending register is zero, `irq_n` is 1 and `rsp_valid` is 0. The reset input acts at once on assertion. The internal logic leaves reset on the second rising clock edge after `rst_n` rises, and it first acts on inputs at the third edge.
- R2: `irq_n` is registered. One edge after any input that changes the pending register or the mask, it reads 0 exactly when (pending AND mask) is nonzero, and 1 otherwise.
- R3: Pending bit 3 (tick) is set once every CLK_FREQ_HZ clock cycles. The first tick sets it at the CLK_FREQ_HZ-th functional edge.
- R4: A command with `cmd_sel`=1 (set-mask) and `cmd_argc`=1 loads `cmd_arg` into the mask. A set-mask command with any other argument count changes nothing.
- R5: A command with `cmd_sel`=0 (acknowledge) and `cmd_argc` other than 0 produces no reply and clears nothing.
- R6: For a valid acknowledge while pending bit 4 (bus) is clear, the reply appears one edge later:
  - `rsp_len` is 1;
  - byte 0 is the pending byte from before that edge;
  - all other reply bytes are 0;
  - the whole pending register is cleared.
- R7: For a valid acknowledge while bit 4 is set:
  - byte 0 is pending AND 0x14, which keeps only bit 4 and bit 2 (autopoll);
  - bytes 1 to size hold the reply buffer and the remaining bytes are 0;
  - `rsp_len` is size+1;
  - only bits 4 and 2 are cleared, and the buffer size drops to 0.
- R8: On `req_done`, the length is first clamped to BUF_DEPTH-2.
  - If the clamped length n is nonzero, the buffer becomes 0x01, n, followed by the first n data bytes, and the size becomes n+2.
  - If n is 0, the buffer becomes the single byte 0x00 and the size becomes 1.
  - In both cases only bit 4 is set.
- R9: An autopoll result is accepted only when all of the following hold: `poll_valid` is high, `poll_len` is nonzero, bit 4 is clear before the edge, and `req_done` is low. An accepted result stores its data unmodified, sets the size to `poll_len` clamped to BUF_DEPTH, and sets bits 4 and 2. A rejected result changes nothing.
- R10: Within one edge, bits being set take precedence over bits being cleared by an acknowledge, and a buffer load takes precedence over the buffer flush. Reply byte k always sits at `rsp_data[8k+7:8k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host command strobe, one cycle |
| cmd_sel | input | 1 | 0 = acknowledge, 1 = set-mask |
| cmd_argc | input | 4 | Number of argument bytes supplied |
| cmd_arg | input | 8 | First argument byte |
| req_done | input | 1 | Explicit bus request completed |
| req_len | input | LEN_W | Bus reply length, 0 = failed |
| req_data | input | (BUF_DEPTH-2)*8 | Bus reply bytes, byte k at [8k+7:8k] |
| poll_valid | input | 1 | Autopoll result offered |
| poll_len | input | LEN_W | Autopoll result length |
| poll_data | input | BUF_DEPTH*8 | Autopoll bytes, byte k at [8k+7:8k] |
| irq_n | output | 1 | Active-low interrupt |
| rsp_valid | output | 1 | Acknowledge reply present, one cycle |
| rsp_len | output | RSP_W | Reply length in bytes |
| rsp_data | output | (BUF_DEPTH+1)*8 | Reply bytes, byte 0 at LSB |

## Verification
The hardest situation to reach is a collision: an acknowledge clears the bus flags on the same edge that a new bus completion or autopoll result arrives. The reply must then report the old buffer, while the register and buffer take the new event. An autopoll offered on that edge must still be refused, because bit 4 was set before the edge. Directed sequences set up a pending bus event and then fire the acknowledge together with a completion, or with an autopoll. A long randomised phase then mixes all four inputs with a high collision rate against a cycle-level reference model, so that tick strobes also land on acknowledge edges.

// File: rtl/irqack_pkg.sv
package irqack_pkg;

  // Pending-register bit positions; reply byte 0 is compared against these.
  localparam int BIT_POLL = 2;
  localparam int BIT_TICK = 3;
  localparam int BIT_BUS  = 4;

  localparam logic [7:0] RESET_MASK = 8'h18;
  localparam logic [7:0] BUS_FLAGS  = 8'h14;

  // Status bytes written at the head of an explicit-request buffer.
  localparam logic [7:0] ST_OK   = 8'h01;
  localparam logic [7:0] ST_FAIL = 8'h00;

  typedef enum logic {
    CMD_ACK     = 1'b0,
    CMD_SETMASK = 1'b1
  } cmd_e;

endpackage

// File: rtl/irqack_tick_div.sv
module irqack_tick_div #(
  parameter int unsigned DIV = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_stb
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_stb = (cnt_q == LAST);

  always_comb begin
    if (tick_stb) cnt_d = '0;
    else          cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/irqack_pend_regs.sv
module irqack_pend_regs
  import irqack_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ack_ok,
  input  logic       mask_wr,
  input  logic [7:0] mask_val,
  input  logic       req_done,
  input  logic       poll_valid,
  input  logic       poll_len_nz,
  output logic [7:0] pend,
  output logic [7:0] mask,
  output logic       poll_load,
  output logic       irq_n
);

  logic [7:0] pend_q, pend_d, mask_q, mask_d;
  logic [7:0] set_v, clr_v;
  logic       pend_en, irq_n_q, irq_n_d;

  // Autopoll is refused while a bus event waits, or when an explicit reply wins.
  assign poll_load = poll_valid & poll_len_nz & ~pend_q[BIT_BUS] & ~req_done;

  always_comb begin
    set_v           = '0;
    set_v[BIT_TICK] = tick;
    set_v[BIT_BUS]  = req_done | poll_load;
    set_v[BIT_POLL] = poll_load;

    clr_v = '0;
    if (ack_ok) clr_v = pend_q[BIT_BUS] ? BUS_FLAGS : 8'hFF;

    pend_en = ack_ok | (|set_v);
    pend_d  = (pend_q & ~clr_v) | set_v;
    mask_d  = mask_wr ? mask_val : mask_q;
    irq_n_d = ~|(pend_d & mask_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      mask_q  <= RESET_MASK;
      irq_n_q <= 1'b1;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (mask_wr) mask_q <= mask_d;
      irq_n_q <= irq_n_d;
    end
  end

  assign pend  = pend_q;
  assign mask  = mask_q;
  assign irq_n = irq_n_q;

endmodule

// File: rtl/irqack_reply_buf.sv
module irqack_reply_buf
  import irqack_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LEN_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_done,
  input  logic [LEN_W-1:0]     req_len,
  input  logic [(DEPTH-2)*8-1:0] req_data,
  input  logic                 poll_load,
  input  logic [LEN_W-1:0]     poll_len,
  input  logic [DEPTH*8-1:0]   poll_data,
  input  logic                 flush,
  output logic [DEPTH*8-1:0]   buf_bytes,
  output logic [LEN_W-1:0]     buf_size
);

  localparam int unsigned PAY = DEPTH - 2;

  logic [LEN_W-1:0]   req_n, poll_n, size_q, size_d;
  logic [DEPTH*8-1:0] bytes_q, bytes_d, req_img, poll_img;
  logic               load, size_en;

  assign req_n  = (req_len  > LEN_W'(PAY))   ? LEN_W'(PAY)   : req_len;
  assign poll_n = (poll_len > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : poll_len;
  assign load   = req_done | poll_load;

  // Per-byte images of both load formats.
  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    if (i == 0) begin : g_head
      assign req_img[i*8 +: 8] = (req_n == '0) ? ST_FAIL : ST_OK;
    end else if (i == 1) begin : g_len
      assign req_img[i*8 +: 8] = (req_n == '0) ? 8'h00 : 8'(req_n);
    end else begin : g_pay
      assign req_img[i*8 +: 8] = (LEN_W'(i - 2) < req_n) ? req_data[(i-2)*8 +: 8] : 8'h00;
    end
    assign poll_img[i*8 +: 8] = (LEN_W'(i) < poll_n) ? poll_data[i*8 +: 8] : 8'h00;
  end

  always_comb begin
    bytes_d = req_done ? req_img : poll_img;
    size_en = load | flush;
    if (req_done)       size_d = (req_n == '0) ? LEN_W'(1) : req_n + LEN_W'(2);
    else if (poll_load) size_d = poll_n;
    else                size_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_q <= '0;
      size_q  <= '0;
    end else begin
      if (load)    bytes_q <= bytes_d;
      if (size_en) size_q  <= size_d;
    end
  end

  assign buf_bytes = bytes_q;
  assign buf_size  = size_q;

endmodule

// File: rtl/irqack_reply_fmt.sv
module irqack_reply_fmt
  import irqack_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LEN_W = 4,
  parameter int unsigned RSP_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ack_ok,
  input  logic [7:0]             pend,
  input  logic [DEPTH*8-1:0]     buf_bytes,
  input  logic [LEN_W-1:0]       buf_size,
  output logic                   rsp_valid,
  output logic [RSP_W-1:0]       rsp_len,
  output logic [(DEPTH+1)*8-1:0] rsp_data
);

  logic                   bus_sel, valid_q;
  logic [RSP_W-1:0]       len_q, len_d;
  logic [(DEPTH+1)*8-1:0] data_q, data_d;

  assign bus_sel = pend[BIT_BUS];

  assign data_d[7:0] = bus_sel ? (pend & BUS_FLAGS) : pend;
  for (genvar k = 1; k <= DEPTH; k++) begin : g_tail
    assign data_d[k*8 +: 8] = (bus_sel && (LEN_W'(k - 1) < buf_size))
                              ? buf_bytes[(k-1)*8 +: 8] : 8'h00;
  end

  always_comb begin
    if (bus_sel) len_d = RSP_W'(buf_size) + RSP_W'(1);
    else         len_d = RSP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      len_q   <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= ack_ok;
      if (ack_ok) begin
        len_q  <= len_d;
        data_q <= data_d;
      end
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_len   = len_q;
  assign rsp_data  = data_q;

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irqack_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 100_000_000,
  parameter int unsigned BUF_DEPTH   = 8,
  localparam int unsigned LEN_W = $clog2(BUF_DEPTH + 1),
  localparam int unsigned RSP_W = $clog2(BUF_DEPTH + 2)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic                       cmd_sel,
  input  logic [3:0]                 cmd_argc,
  input  logic [7:0]                 cmd_arg,
  input  logic                       req_done,
  input  logic [LEN_W-1:0]           req_len,
  input  logic [(BUF_DEPTH-2)*8-1:0] req_data,
  input  logic                       poll_valid,
  input  logic [LEN_W-1:0]           poll_len,
  input  logic [BUF_DEPTH*8-1:0]     poll_data,
  output logic                       irq_n,
  output logic                       rsp_valid,
  output logic [RSP_W-1:0]           rsp_len,
  output logic [(BUF_DEPTH+1)*8-1:0] rsp_data
);

  // Reset: asserted asynchronously, released through two flops.
  logic rs1_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q     <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rs1_q     <= 1'b1;
      rst_int_n <= rs1_q;
    end
  end

  logic                   tick_stb, ack_ok, mask_wr, poll_load;
  logic [7:0]             pend, mask;
  logic [BUF_DEPTH*8-1:0] buf_bytes;
  logic [LEN_W-1:0]       buf_size;

  assign ack_ok  = cmd_valid && (cmd_e'(cmd_sel) == CMD_ACK)     && (cmd_argc == 4'd0);
  assign mask_wr = cmd_valid && (cmd_e'(cmd_sel) == CMD_SETMASK) && (cmd_argc == 4'd1);

  irqack_tick_div #(.DIV(CLK_FREQ_HZ)) tick_i (
    .clk(clk), .rst_n(rst_int_n), .tick_stb(tick_stb)
  );

  irqack_pend_regs pend_i (
    .clk(clk), .rst_n(rst_int_n), .tick(tick_stb), .ack_ok(ack_ok),
    .mask_wr(mask_wr), .mask_val(cmd_arg), .req_done(req_done),
    .poll_valid(poll_valid), .poll_len_nz(poll_len != '0),
    .pend(pend), .mask(mask), .poll_load(poll_load), .irq_n(irq_n)
  );

  irqack_reply_buf #(.DEPTH(BUF_DEPTH), .LEN_W(LEN_W)) buf_i (
    .clk(clk), .rst_n(rst_int_n), .req_done(req_done), .req_len(req_len),
    .req_data(req_data), .poll_load(poll_load), .poll_len(poll_len),
    .poll_data(poll_data), .flush(ack_ok & pend[BIT_BUS]),
    .buf_bytes(buf_bytes), .buf_size(buf_size)
  );

  irqack_reply_fmt #(.DEPTH(BUF_DEPTH), .LEN_W(LEN_W), .RSP_W(RSP_W)) fmt_i (
    .clk(clk), .rst_n(rst_int_n), .ack_ok(ack_ok), .pend(pend),
    .buf_bytes(buf_bytes), .buf_size(buf_size), .rsp_valid(rsp_valid),
    .rsp_len(rsp_len), .rsp_data(rsp_data)
  );

  logic unused_mask;
  assign unused_mask = ^mask;

endmodule

// File: rtl/irq_ack_ctrl_chk.sv
module irq_ack_ctrl_chk #(
  parameter int unsigned BUF_DEPTH = 8,
  localparam int unsigned RSP_W = $clog2(BUF_DEPTH + 2)
) (
  input logic                       clk,
  input logic                       rst_int_n,
  input logic                       tick_stb,
  input logic                       cmd_valid,
  input logic                       cmd_sel,
  input logic [3:0]                 cmd_argc,
  input logic                       req_done,
  input logic                       poll_valid,
  input logic                       irq_n,
  input logic                       rsp_valid,
  input logic [RSP_W-1:0]           rsp_len,
  input logic [(BUF_DEPTH+1)*8-1:0] rsp_data
);

  AST_RSP_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid |-> $past(cmd_valid && !cmd_sel && cmd_argc == 4'd0)); // R5

  AST_RSP_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid |-> (rsp_len >= RSP_W'(1) && rsp_len <= RSP_W'(BUF_DEPTH + 1))); // R7

  AST_BUS_HEAD_FLAGS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_valid && rsp_len > RSP_W'(1)) |-> ((rsp_data[7:0] & 8'hEB) == 8'h00)); // R7

  AST_SINGLE_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_valid && rsp_len == RSP_W'(1)) |-> (rsp_data[(BUF_DEPTH+1)*8-1:8] == '0)); // R6

  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(irq_n) |-> $past(tick_stb || req_done || poll_valid || cmd_valid)); // R2

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(irq_n) |-> $past(cmd_valid)); // R2

endmodule

bind irq_ack_ctrl irq_ack_ctrl_chk #(.BUF_DEPTH(BUF_DEPTH)) chk_i (
  .clk(clk), .rst_int_n(rst_int_n), .tick_stb(tick_stb), .cmd_valid(cmd_valid),
  .cmd_sel(cmd_sel), .cmd_argc(cmd_argc), .req_done(req_done),
  .poll_valid(poll_valid), .irq_n(irq_n), .rsp_valid(rsp_valid),
  .rsp_len(rsp_len), .rsp_data(rsp_data)
);

// File: tb/irq_ack_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_ack_ctrl_tb_top;

  localparam int DIV = 5000;
  localparam int BUF = 8;
  localparam int PAY = BUF - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, cmd_sel = 0;
  logic [3:0] cmd_argc = 0;
  logic [7:0] cmd_arg = 0;
  logic req_done = 0;
  logic [3:0] req_len = 0;
  logic [PAY*8-1:0] req_data = '0;
  logic poll_valid = 0;
  logic [3:0] poll_len = 0;
  logic [BUF*8-1:0] poll_data = '0;
  logic irq_n, rsp_valid;
  logic [3:0] rsp_len;
  logic [(BUF+1)*8-1:0] rsp_data;

  always #5 clk = ~clk;

  irq_ack_ctrl #(.CLK_FREQ_HZ(DIV), .BUF_DEPTH(BUF)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
    .cmd_argc(cmd_argc), .cmd_arg(cmd_arg), .req_done(req_done),
    .req_len(req_len), .req_data(req_data), .poll_valid(poll_valid),
    .poll_len(poll_len), .poll_data(poll_data), .irq_n(irq_n),
    .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_data(rsp_data)
  );

  int errors = 0, checks = 0;
  string ctx = "R1";

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int since = 0, m_tcnt = 0, m_pend = 0, m_mask = 'h18, m_size = 0;
  int m_buf[BUF];
  bit m_rv = 0;
  int m_rl = 0;
  int m_rd[BUF+1];

  always @(posedge clk) begin
    if (!rst_n) since = 0; else if (since < 3) since++;
    if (since < 3) begin
      m_tcnt = 0; m_pend = 0; m_mask = 'h18; m_size = 0; m_rv = 0;
      foreach (m_buf[i]) m_buf[i] = 0;
    end else begin
      int p, clr, set, n;
      bit tick, ack, flush;
      p = m_pend; clr = 0; set = 0; flush = 0;
      tick = (m_tcnt == DIV - 1);
      m_tcnt = tick ? 0 : m_tcnt + 1;
      ack = cmd_valid && !cmd_sel && cmd_argc == 0;
      m_rv = ack;
      if (ack) begin
        if (p & 'h10) begin
          m_rd[0] = p & 'h14;
          for (int i = 0; i < BUF; i++) m_rd[i+1] = (i < m_size) ? m_buf[i] : 0;
          m_rl = m_size + 1; clr = 'h14; flush = 1;
        end else begin
          m_rd[0] = p;
          for (int i = 1; i <= BUF; i++) m_rd[i] = 0;
          m_rl = 1; clr = 'hFF;
        end
      end
      if (tick) set |= 'h08;
      if (req_done) begin
        n = (req_len > PAY) ? PAY : int'(req_len);
        foreach (m_buf[i]) m_buf[i] = 0;
        if (n > 0) begin
          m_buf[0] = 1; m_buf[1] = n;
          for (int k = 0; k < n; k++) m_buf[k+2] = int'(req_data[k*8 +: 8]);
          m_size = n + 2;
        end else m_size = 1;
        set |= 'h10;
      end else if (poll_valid && poll_len != 0 && !(p & 'h10)) begin
        n = (poll_len > BUF) ? BUF : int'(poll_len);
        foreach (m_buf[i]) m_buf[i] = (i < n) ? int'(poll_data[i*8 +: 8]) : 0;
        m_size = n; set |= 'h14;
      end else if (flush) m_size = 0;
      m_pend = (p & ~clr & 'hFF) | set;
      if (cmd_valid && cmd_sel && cmd_argc == 1) m_mask = cmd_arg;
    end
  end

  bit started = 0;
  always @(negedge clk) begin
    if (started) begin
      check({ctx, " R2 irq_n"}, irq_n, ((m_pend & m_mask) != 0) ? 0 : 1);
      check({ctx, " rsp_valid"}, rsp_valid, m_rv);
      if (rsp_valid && m_rv) begin
        check({ctx, " rsp_len"}, rsp_len, m_rl);
        for (int i = 0; i <= BUF; i++)
          check({ctx, " rsp byte"}, rsp_data[i*8 +: 8], m_rd[i]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic cmd(bit sel, int argc, int arg);
    cmd_valid = 1; cmd_sel = sel; cmd_argc = 4'(argc); cmd_arg = 8'(arg);
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic req(int len, logic [PAY*8-1:0] d);
    req_done = 1; req_len = 4'(len); req_data = d;
    @(negedge clk); req_done = 0;
  endtask

  task automatic poll(int len, logic [BUF*8-1:0] d);
    poll_valid = 1; poll_len = 4'(len); poll_data = d;
    @(negedge clk); poll_valid = 0;
  endtask

  task automatic exp_rsp(string tag, int len, logic [(BUF+1)*8-1:0] d);
    check({tag, " valid"}, rsp_valid, 1);
    check({tag, " len"}, rsp_len, len);
    for (int i = 0; i <= BUF; i++) check({tag, " byte"}, rsp_data[i*8 +: 8], d[i*8 +: 8]);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- test sequence ----------------
  initial begin
    idle(3);
    started = 1;
    check("R1 irq_n in reset", irq_n, 1);
    check("R1 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1;
    idle(5);
    check("R1 irq_n after reset", irq_n, 1);

    ctx = "R6"; cmd(0, 0, 0);
    exp_rsp("R6 empty ack", 1, '0);

    ctx = "R4"; cmd(1, 2, 'h00); idle(1);
    ctx = "R5"; cmd(0, 1, 0);
    check("R5 no reply for bad argc", rsp_valid, 0);

    ctx = "R8"; req(3, 48'hCC_BB_AA);
    check("R8 irq after request", irq_n, 0);
    cmd(0, 0, 0);
    exp_rsp("R7 request reply", 6, 72'hCC_BB_AA_03_01_10);
    check("R7 irq cleared", irq_n, 1);

    req(0, '0); cmd(0, 0, 0);
    exp_rsp("R8 failed request", 2, 72'h00_10);

    req(9, 48'h66_55_44_33_22_11); cmd(0, 0, 0);
    exp_rsp("R8 clamped length", 9, 72'h66_55_44_33_22_11_06_01_10);

    ctx = "R9"; poll(2, 64'h5A_A5); poll(3, 64'h77_77_77);
    poll(0, 64'h1); cmd(0, 0, 0);
    exp_rsp("R9 first autopoll kept", 3, 72'h5A_A5_14);
    poll(0, 64'h9); cmd(0, 0, 0);
    exp_rsp("R9 zero-length poll ignored", 1, '0);

    ctx = "R10"; poll(8, 64'h88_77_66_55_44_33_22_11);
    req_done = 1; req_len = 1; req_data = 48'hEE;
    poll_valid = 1; poll_len = 2; poll_data = 64'h99;
    cmd_valid = 1; cmd_sel = 0; cmd_argc = 0;
    @(negedge clk);
    req_done = 0; poll_valid = 0; cmd_valid = 0;
    exp_rsp("R10 reply shows old buffer", 9, 72'h88_77_66_55_44_33_22_11_14);
    check("R10 new event still pending", irq_n, 0);
    cmd(0, 0, 0);
    exp_rsp("R10 new buffer", 4, 72'hEE_01_01_10);

    ctx = "R4"; cmd(1, 1, 'h00); req(1, 48'h1);
    check("R4 masked pending keeps irq high", irq_n, 1);
    cmd(1, 1, 'h10);
    check("R4 unmask raises irq", irq_n, 0);
    cmd(0, 0, 0); cmd(1, 1, 'h08);

    ctx = "R3"; idle(DIV + 20);
    check("R3 tick raised irq", irq_n, 0);
    req(2, 48'hBE_EF);
    ctx = "R7"; cmd(0, 0, 0);
    exp_rsp("R7 bus reply, tick untouched", 5, 72'hBE_EF_02_01_10);
    check("R7 tick still pending", irq_n, 0);
    cmd(0, 0, 0);
    exp_rsp("R6 tick reported", 1, 72'h08);
    cmd(1, 1, 'h18);

    ctx = "R10 mixed";
    for (int c = 0; c < 20000; c++) begin
      int r;
      r = int'($urandom_range(0, 99));
      cmd_valid = (r < 25); cmd_sel = (r < 6);
      cmd_argc = ($urandom_range(0, 4) == 0) ? 4'd1 : (cmd_sel ? 4'd1 : 4'd0);
      cmd_arg = 8'($urandom);
      req_done = ($urandom_range(0, 9) == 0); req_len = 4'($urandom_range(0, 8));
      req_data = {$urandom, $urandom};
      poll_valid = ($urandom_range(0, 7) == 0); poll_len = 4'($urandom_range(0, 9));
      poll_data = {$urandom, $urandom};
      @(negedge clk);
    end
    cmd_valid = 0; req_done = 0; poll_valid = 0;
    idle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule